// File: doc/BRIEF.md
# Rectangle Fill and Scroll Engine

This block is a small 2D drawing engine. Software programs a set of write-only configuration registers and the engine then walks a rectangle on a pixel store, issuing one read and/or one write request per pixel on a simple synchronous frame-store port. Two operations are supported. The first is a solid fill with a foreground colour, modified by a raster operation code. The second is a block copy from a source origin to a destination origin, intended for vertical scrolling.

The pixel store is addressed in 32-bit pixels with a fixed line pitch of 2048 pixels, so pixel (x, y) lives at word address y*2048 + x whatever the visible resolution. Writing the width register is the trigger. While an operation runs the engine reports busy and holds off further register writes with a ready signal. None of those writes is dropped. For a copy whose destination lies below its source, rows are visited bottom-up so that overlapping areas come out intact.

Top module: `rect_blit_engine`

## Requirements
- R1: After reset the engine is idle: `busy` is low, `cfg_ready` is high and `mem_req` is low. No request is issued while idle.
- R2: While `busy` is high, `cfg_ready` is low. A register write presented during an operation stays pending, lands only after the operation ends, and does not alter the running operation.
- R3: Register addresses are OPCODE=0, ORG_Y=1, ORG_X=2, HEIGHT=3, WIDTH=4, DST_Y=5, DST_X=6, FG=7, ROP=8. Opcode 0x08 fills every pixel (ORG_X+c, ORG_Y+r), for c < WIDTH and r < HEIGHT, at word address y*2048+x, and touches no pixel outside that set. FG is written unmodified, with blue in bits 23:16, green in 15:8 and red in 7:0.
- R4: A fill with ROP code 0x83 writes FG to each pixel without reading it. Any ROP code other than 0x85 or 0x86 behaves like 0x83.
- R5: A fill with ROP code 0x86 reads each pixel and writes FG XOR the old value.
- R6: A fill with ROP code 0x85 reads each pixel and writes the old value back, leaving the store unchanged.
- R7: Opcode 0x0B copies each source pixel (ORG_X+c, ORG_Y+r) to (DST_X+c, DST_Y+r) unchanged, whatever the ROP code.
- R8: For a copy with DST_Y > ORG_Y, rows go bottom row first; otherwise they go top row first. Columns always go left to right, so vertically overlapping copies are correct.
- R9: A WIDTH write with data 0, a zero HEIGHT register, or an opcode other than 0x08 or 0x0B starts nothing: `busy` stays low and no request is made.
- R10: `busy` rises in the cycle after a starting WIDTH write is accepted. It falls in the cycle after the last pixel write is accepted.
- R11: A request holds `mem_addr`, `mem_we` and `mem_wdata` stable until a cycle with `mem_gnt` high accepts it. Read data on `mem_rdata` is taken in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register write request |
| cfg_ready | output | 1 | Register write accepted when high together with cfg_valid |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Frame-store request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_gnt | input | 1 | Frame store accepts the current request |
| mem_addr | output | 22 | Pixel word address |
| mem_wdata | output | 32 | Pixel write data |
| mem_rdata | input | 32 | Pixel read data, valid the cycle after a read is accepted |

## Verification
Two events can meet in one cycle: a register write pending on the configuration port, and acceptance of the final pixel write. To provoke this, the bench presents a foreground change right after triggering a fill and keeps it valid. The frame store meanwhile stalls on a fixed grant pattern. The bench judges the result by three things. The write must be taken only at a point where busy is low and every pixel write has already been counted. The finished rectangle must still carry the old colour. The next fill must carry the new one.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [7:0] OP_FILL   = 8'h08;
  localparam logic [7:0] OP_SCROLL = 8'h0B;
  localparam logic [7:0] ROP_NEW   = 8'h83;
  localparam logic [7:0] ROP_OLD   = 8'h85;
  localparam logic [7:0] ROP_XOR   = 8'h86;

  localparam logic [3:0] RA_OP  = 4'd0;
  localparam logic [3:0] RA_OY  = 4'd1;
  localparam logic [3:0] RA_OX  = 4'd2;
  localparam logic [3:0] RA_H   = 4'd3;
  localparam logic [3:0] RA_W   = 4'd4;
  localparam logic [3:0] RA_DY  = 4'd5;
  localparam logic [3:0] RA_DX  = 4'd6;
  localparam logic [3:0] RA_FG  = 4'd7;
  localparam logic [3:0] RA_ROP = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_LATCH = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [7:0]         op,
  output logic [7:0]         rop,
  output logic [DATA_W-1:0]  fg,
  output logic [COORD_W-1:0] org_y,
  output logic [COORD_W-1:0] org_x,
  output logic [COORD_W-1:0] dst_y,
  output logic [COORD_W-1:0] dst_x,
  output logic [COORD_W-1:0] ht,
  output logic [COORD_W-1:0] wd,
  output logic               start
);
  logic [7:0]         op_d, rop_d;
  logic [DATA_W-1:0]  fg_d;
  logic [COORD_W-1:0] oy_d, ox_d, ty_d, tx_d, ht_d, wd_d;
  logic [COORD_W-1:0] coord_in;
  logic               op_ok;

  assign coord_in = wr_data[COORD_W-1:0];
  assign op_ok    = (op == OP_FILL) || (op == OP_SCROLL);
  assign start    = wr_en && (wr_addr == RA_W) && (coord_in != '0) && (ht != '0) && op_ok;

  always_comb begin
    op_d = op; rop_d = rop; fg_d = fg;
    oy_d = org_y; ox_d = org_x; ty_d = dst_y; tx_d = dst_x;
    ht_d = ht; wd_d = wd;
    if (wr_en) begin
      case (wr_addr)
        RA_OP:   op_d  = wr_data[7:0];
        RA_OY:   oy_d  = coord_in;
        RA_OX:   ox_d  = coord_in;
        RA_H:    ht_d  = coord_in;
        RA_W:    wd_d  = coord_in;
        RA_DY:   ty_d  = coord_in;
        RA_DX:   tx_d  = coord_in;
        RA_FG:   fg_d  = wr_data;
        RA_ROP:  rop_d = wr_data[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= '0; rop <= ROP_NEW; fg <= '0;
      org_y <= '0; org_x <= '0; dst_y <= '0; dst_x <= '0;
      ht <= '0; wd <= '0;
    end else begin
      op <= op_d; rop <= rop_d; fg <= fg_d;
      org_y <= oy_d; org_x <= ox_d; dst_y <= ty_d; dst_x <= tx_d;
      ht <= ht_d; wd <= wd_d;
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step,
  input  logic               bottom_up,
  input  logic [COORD_W-1:0] ht,
  input  logic [COORD_W-1:0] wd,
  output logic [COORD_W-1:0] row_off,
  output logic [COORD_W-1:0] col,
  output logic               last
);
  logic [COORD_W-1:0] col_q, col_d, row_q, row_d;
  logic               row_end;

  assign row_end = (col_q == wd - COORD_W'(1));
  assign last    = row_end && (row_q == ht - COORD_W'(1));
  assign col     = col_q;
  assign row_off = bottom_up ? (ht - COORD_W'(1) - row_q) : row_q;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (start) begin
      col_d = '0;
      row_d = '0;
    end else if (step) begin
      if (row_end) begin
        col_d = '0;
        row_d = row_q + COORD_W'(1);
      end else begin
        col_d = col_q + COORD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (start || step) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int COORD_W  = 11,
  parameter int PITCH_LG = 11,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = COORD_W + PITCH_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               is_copy,
  input  logic [7:0]         rop,
  input  logic [DATA_W-1:0]  fg,
  input  logic [COORD_W-1:0] org_y,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] row_off,
  input  logic [COORD_W-1:0] col,
  input  logic               last,
  input  logic               mem_gnt,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               step,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata
);
  seq_state_e         state_q, state_d;
  logic [DATA_W-1:0]  pix_q, pix_d;
  logic               need_rd;
  logic [COORD_W-1:0] wy, wx;
  logic [ADDR_W-1:0]  src_a, dst_a;

  assign need_rd = is_copy || (rop == ROP_OLD) || (rop == ROP_XOR);
  assign wy      = is_copy ? dst_y : org_y;
  assign wx      = is_copy ? dst_x : org_x;
  assign src_a   = ((ADDR_W'(org_y) + ADDR_W'(row_off)) << PITCH_LG) + ADDR_W'(org_x) + ADDR_W'(col);
  assign dst_a   = ((ADDR_W'(wy) + ADDR_W'(row_off)) << PITCH_LG) + ADDR_W'(wx) + ADDR_W'(col);

  assign busy     = (state_q != ST_IDLE);
  assign mem_req  = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we   = (state_q == ST_WRITE);
  assign mem_addr = (state_q == ST_READ && is_copy) ? src_a : dst_a;
  assign step     = (state_q == ST_WRITE) && mem_gnt;

  always_comb begin
    if (is_copy || rop == ROP_OLD) mem_wdata = pix_q;
    else if (rop == ROP_XOR)       mem_wdata = fg ^ pix_q;
    else                           mem_wdata = fg;
  end

  always_comb begin
    state_d = state_q;
    pix_d   = pix_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = need_rd ? ST_READ : ST_WRITE;
      ST_READ:  if (mem_gnt) state_d = ST_LATCH;
      ST_LATCH: begin
        pix_d   = mem_rdata;
        state_d = ST_WRITE;
      end
      ST_WRITE: if (mem_gnt) state_d = last ? ST_IDLE : (need_rd ? ST_READ : ST_WRITE);
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pix_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LATCH) pix_q <= pix_d;
    end
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int COORD_W  = 11,
  parameter int PITCH_LG = 11,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = COORD_W + PITCH_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [3:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [7:0]         op, rop;
  logic [DATA_W-1:0]  fg;
  logic [COORD_W-1:0] org_y, org_x, dst_y, dst_x, ht, wd, row_off, col;
  logic               start, step, last, is_copy, bottom_up, wr_en;

  assign cfg_ready = !busy;
  assign wr_en     = cfg_valid && cfg_ready;
  assign is_copy   = (op == OP_SCROLL);
  assign bottom_up = is_copy && (dst_y > org_y);

  blit_regs #(.COORD_W(COORD_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .op(op), .rop(rop), .fg(fg), .org_y(org_y), .org_x(org_x),
    .dst_y(dst_y), .dst_x(dst_x), .ht(ht), .wd(wd), .start(start)
  );

  blit_walker #(.COORD_W(COORD_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .bottom_up(bottom_up),
    .ht(ht), .wd(wd), .row_off(row_off), .col(col), .last(last)
  );

  blit_seq #(.COORD_W(COORD_W), .PITCH_LG(PITCH_LG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_copy(is_copy), .rop(rop), .fg(fg),
    .org_y(org_y), .org_x(org_x), .dst_y(dst_y), .dst_x(dst_x),
    .row_off(row_off), .col(col), .last(last), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .step(step), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/rect_blit_engine_chk.sv
module rect_blit_engine_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cfg_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_held_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cfg_ready);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_we && mem_gnt));

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  p_wdata_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_gnt) |=> $stable(mem_wdata));
endmodule

bind rect_blit_engine rect_blit_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_ready(cfg_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/rect_blit_engine_tb_top.sv
`timescale 1ns/1ps
module rect_blit_engine_tb_top;
  import blit_pkg::*;
  localparam int PITCH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, mem_req, mem_we;
  logic        mem_gnt = 1'b0;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  rect_blit_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [int];
  int total = 0, bad = 0;
  int pcyc = 0, nwr = 0, nrd = 0, last_wr = 0, idle_cyc = 0, first_wr = -1;
  int gnt_mode = 0, rd_addr = 0, acc_nwr = 0;
  bit rd_pend = 0, acc_busy = 0, done = 0;

  function automatic logic [31:0] seed(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h00A5A5A5;
  endfunction

  function automatic logic [31:0] peek(int a);
    if (mem.exists(a)) return mem[a];
    return seed(a);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) pcyc++;

  always @(posedge clk) begin
    if (pcyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) act=%0d exp=%0d", pcyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // frame-store model: grant pattern, read return one cycle after accept
  always @(negedge clk) begin
    if (rd_pend) begin
      mem_rdata = peek(rd_addr);
      rd_pend = 0;
    end
    mem_gnt = (gnt_mode == 0) ? 1'b1 : ((pcyc % 3) != 0);
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        if (first_wr < 0) first_wr = int'(mem_addr);
        mem[int'(mem_addr)] = mem_wdata;
        nwr++;
        last_wr = pcyc;
      end else begin
        rd_pend = 1;
        rd_addr = int'(mem_addr);
        nrd++;
      end
    end
  end

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = d;
    while (!cfg_ready) @(negedge clk);
    acc_nwr = nwr; acc_busy = busy;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    idle_cyc = pcyc;
  endtask

  task automatic clear_counts();
    nwr = 0; nrd = 0; first_wr = -1;
  endtask

  task automatic start_fill(int x, int y, int w, int h, logic [31:0] f, logic [7:0] r);
    cfg_write(RA_ROP, 32'(r)); cfg_write(RA_FG, f); cfg_write(RA_OP, 32'(OP_FILL));
    cfg_write(RA_OY, y); cfg_write(RA_OX, x); cfg_write(RA_H, h); cfg_write(RA_W, w);
  endtask

  task automatic run_fill(int x, int y, int w, int h, logic [31:0] f, logic [7:0] r, string rtag);
    logic [31:0] ex[$];
    int nbad = 0;
    logic [31:0] av = 0, ev = 0;
    mem.delete();
    for (int ri = 0; ri < h; ri++)
      for (int ci = 0; ci < w; ci++) begin
        int a = (y + ri) * PITCH + x + ci;
        ex.push_back(r == ROP_XOR ? (f ^ peek(a)) : (r == ROP_OLD ? peek(a) : f));
      end
    clear_counts();
    start_fill(x, y, w, h, f, r);
    chk(busy == 1'b1, "R10", "busy after trigger", busy, 1);
    wait_idle();
    chk(idle_cyc == last_wr + 1, "R10", "busy fall cycle", idle_cyc, last_wr + 1);
    for (int ri = 0; ri < h; ri++)
      for (int ci = 0; ci < w; ci++) begin
        int a = (y + ri) * PITCH + x + ci;
        if (peek(a) !== ex[ri * w + ci]) begin
          if (nbad == 0) begin av = peek(a); ev = ex[ri * w + ci]; end
          nbad++;
        end
      end
    chk(nbad == 0, rtag, "fill contents", av, ev);
    chk(nwr == w * h, "R3", "fill write count", nwr, w * h);
    chk(nrd == ((r == ROP_OLD || r == ROP_XOR) ? w * h : 0), rtag, "fill read count", nrd,
        (r == ROP_OLD || r == ROP_XOR) ? w * h : 0);
    chk(!mem.exists(y * PITCH + x + w) && !mem.exists((y + h) * PITCH + x) &&
        !mem.exists(y * PITCH + x - 1) && !mem.exists((y - 1) * PITCH + x),
        "R3", "outside untouched", mem.size(), w * h);
  endtask

  task automatic run_copy(int sx, int sy, int dx, int dy, int w, int h, logic [7:0] r);
    logic [31:0] ex[$];
    int nbad = 0;
    logic [31:0] av = 0, ev = 0;
    int fw;
    mem.delete();
    for (int ri = 0; ri < h; ri++)
      for (int ci = 0; ci < w; ci++) ex.push_back(seed((sy + ri) * PITCH + sx + ci));
    clear_counts();
    cfg_write(RA_ROP, 32'(r)); cfg_write(RA_OP, 32'(OP_SCROLL));
    cfg_write(RA_OY, sy); cfg_write(RA_OX, sx); cfg_write(RA_DY, dy); cfg_write(RA_DX, dx);
    cfg_write(RA_H, h); cfg_write(RA_W, w);
    chk(busy == 1'b1, "R10", "busy after copy trigger", busy, 1);
    wait_idle();
    for (int ri = 0; ri < h; ri++)
      for (int ci = 0; ci < w; ci++) begin
        int a = (dy + ri) * PITCH + dx + ci;
        if (peek(a) !== ex[ri * w + ci]) begin
          if (nbad == 0) begin av = peek(a); ev = ex[ri * w + ci]; end
          nbad++;
        end
      end
    chk(nbad == 0, "R7", "copy contents", av, ev);
    chk(nwr == w * h && nrd == w * h, "R7", "copy access counts", nwr * 1000 + nrd, w * h * 1001);
    fw = (dy + ((dy > sy) ? h - 1 : 0)) * PITCH + dx;
    chk(first_wr == fw, "R8", "first row of copy", first_wr, fw);
  endtask

  task automatic run_nop(logic [7:0] op, int w, int h);
    bit saw_busy = 0;
    clear_counts();
    cfg_write(RA_OP, 32'(op)); cfg_write(RA_OY, 7); cfg_write(RA_OX, 7);
    cfg_write(RA_H, h); cfg_write(RA_W, w);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy) saw_busy = 1;
    end
    chk(!saw_busy && nwr == 0 && nrd == 0, "R9", "no operation started",
        saw_busy * 100 + nwr + nrd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && cfg_ready == 1'b1 && mem_req == 1'b0, "R1", "reset state",
        {busy, cfg_ready, mem_req}, 3'b010);

    // R3/R4 sweep over small rectangles, with and without stalls
    for (int w = 1; w <= 5; w++)
      for (int h = 1; h <= 4; h++) begin
        gnt_mode = (w + h) % 2;
        run_fill(w * 7, 100 + h * 3, w, h, {8'h00, 8'(w * 16), 8'(h * 16), 8'h5C}, ROP_NEW, "R4");
      end

    // R3 colour packing passes through unchanged
    gnt_mode = 0;
    run_fill(2045, 9, 3, 2, 32'h00112233, ROP_NEW, "R3");

    // R4 unknown code acts as new-only
    run_fill(20, 20, 3, 3, 32'h00ABCDEF, 8'h42, "R4");

    // R5 xor and R6 old-only, with stalls
    for (int m = 0; m < 2; m++) begin
      gnt_mode = m;
      run_fill(30, 40, 4, 3, 32'h00FF00FF, ROP_XOR, "R5");
      run_fill(31, 41, 3, 4, 32'h00123456, ROP_OLD, "R6");
    end

    // R7/R8 copies: downward overlap, upward overlap, side move
    for (int m = 0; m < 2; m++) begin
      gnt_mode = m;
      run_copy(40, 10, 40, 12, 3, 5, ROP_OLD);
      run_copy(50, 30, 50, 27, 4, 4, ROP_NEW);
      run_copy(5, 60, 200, 60, 2, 3, ROP_XOR);
      run_copy(8, 70, 8, 71, 1, 1, ROP_OLD);
    end

    // R9 zero sizes and unsupported opcode
    gnt_mode = 0;
    run_nop(OP_FILL, 0, 3);
    run_nop(OP_FILL, 4, 0);
    run_nop(8'h0A, 4, 3);

    // R2 write presented during a fill is held, then applied
    gnt_mode = 1;
    mem.delete();
    clear_counts();
    start_fill(60, 80, 3, 2, 32'h000000AA, ROP_NEW);
    chk(busy == 1'b1, "R2", "busy before held write", busy, 1);
    cfg_write(RA_FG, 32'h000000BB);
    chk(acc_busy == 1'b0 && acc_nwr == 6, "R2", "held write accepted after last pixel",
        acc_busy * 100 + acc_nwr, 6);
    chk(peek(80 * PITCH + 60) == 32'hAA && peek(81 * PITCH + 62) == 32'hAA, "R2",
        "running fill kept old colour", peek(81 * PITCH + 62), 32'hAA);
    clear_counts();
    cfg_write(RA_OY, 90); cfg_write(RA_OX, 1); cfg_write(RA_H, 1); cfg_write(RA_W, 1);
    wait_idle();
    chk(peek(90 * PITCH + 1) == 32'hBB, "R2", "held colour applied", peek(90 * PITCH + 1), 32'hBB);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule